// File: doc/BRIEF.md
# Triple-Lane Voted Pipeline

This block carries a data word through seven pipeline stages that are built three times over, as three identical lanes. Each lane-stage holds a register that loads the result of a small per-stage transform. After every stage, a bitwise two-of-three voter merges the three lane outputs into one word. That voted word is the input to the next stage in all three lanes. A wrong result in one lane at one stage is therefore replaced before it can spread, and each stage boundary tolerates its own single-lane failure.

The carried record is a valid bit, two parity bits and a 26-bit payload. Stage `s` adds `STEP + s` to the payload, modulo 2^26, and regenerates the parity. The valid bit passes through unchanged and is voted like the data. For every stage, a fault port can override the registered output of one chosen lane with an arbitrary record for as long as it is held. A per-stage mismatch flag shows when any lane disagrees with that stage's vote.

Top module: `tmr_vote_pipe`

## Requirements
- R1: While `rst_ni` is low, and after its release before any input is taken, `valid_o`, `data_o`, `parity_o` and `mismatch_o` are all zero.
- R2: `valid_o` equals the `valid_i` value sampled seven rising edges earlier.
- R3: When `valid_o` is high, `data_o` equals the `data_i` sampled seven edges earlier plus `7*STEP + 21`, modulo 2^26. Stage `s` (0..6) adds `STEP + s`.
- R4: `parity_o[0]` is the XOR of `data_o[12:0]`, and `parity_o[1]` is the XOR of `data_o[25:13]`.
- R5: A fault record injected on one lane of a stage changes neither the data, the parity nor the valid bit that leave that stage, because every bit is a two-of-three majority.
- R6: Outputs stay correct when all seven stages are faulted in the same cycle, each in a different or arbitrary single lane.
- R7: `mismatch_o[s]` is high in a cycle exactly when stage `s` has an active fault whose 29-bit record `{valid, parity[1:0], payload[25:0]}` differs from the true stage value. A fault is active when `fault_en_i[s]` is set and `fault_lane_i[2s+1:2s]` is 0, 1 or 2. The lane code 3 selects no lane and has no effect.
- R8: The voted value is reloaded into all lanes. In a cycle with no active fault, every bit of `mismatch_o` is zero, including the cycle right after a faulted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input record valid |
| data_i | input | 26 | Input payload |
| fault_en_i | input | 7 | Per-stage fault enable |
| fault_lane_i | input | 14 | Per-stage lane select, 2 bits per stage, stage s at [2s+1:2s], 3 = none |
| fault_val_i | input | 203 | Per-stage forced record, 29 bits per stage, stage s at [29s+28:29s] |
| valid_o | output | 1 | Voted output valid |
| data_o | output | 26 | Voted output payload |
| parity_o | output | 2 | Voted output parity |
| mismatch_o | output | 7 | Per-stage lane disagreement flag |

## Verification
The checker watches four things on every cycle: the seven-cycle valid latency, the end-to-end payload offset, the output parity, and two rules for the mismatch flags. The flags are silent when no fault is driven, and a flag can only rise at a stage whose fault enable is set. Whether one corrupted lane at every stage, in varying lane positions, really leaves the output correct can only be shown by the bench's scenarios. The same holds for a flag rising only when the forced record truly differs, and for the lane code 3 being ignored. The bench tracks the true value of each stage and compares against it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned PAY_W  = 26;
  localparam int unsigned PAR_W  = 2;
  localparam int unsigned REC_W  = 1 + PAR_W + PAY_W;
  localparam int unsigned N_LANE = 3;
  localparam int unsigned LANE_W = 2;

  typedef struct packed {
    logic             vld;
    logic [PAR_W-1:0] par;
    logic [PAY_W-1:0] pay;
  } rec_t;

  function automatic logic [PAR_W-1:0] calc_par(input logic [PAY_W-1:0] p);
    calc_par = {^p[PAY_W-1:PAY_W/2], ^p[PAY_W/2-1:0]};
  endfunction
endpackage

// File: rtl/tmr_lane_stage.sv
module tmr_lane_stage
  import tmr_pkg::*;
#(
  parameter int unsigned STEP      = 32'h0013_579B,
  parameter int unsigned STAGE_IDX = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  rec_t in_i,
  input  logic fault_hit_i,
  input  rec_t fault_val_i,
  output rec_t out_o
);
  localparam logic [PAY_W-1:0] ADD = PAY_W'(STEP + STAGE_IDX);

  rec_t nxt, q;

  always_comb begin
    nxt.vld = in_i.vld;
    nxt.pay = in_i.pay + ADD;
    nxt.par = calc_par(nxt.pay);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign out_o = fault_hit_i ? fault_val_i : q;
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
  import tmr_pkg::*;
(
  input  rec_t a_i,
  input  rec_t b_i,
  input  rec_t c_i,
  output rec_t maj_o,
  output logic mis_o
);
  assign maj_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign mis_o = (a_i != maj_o) || (b_i != maj_o) || (c_i != maj_o);
endmodule

// File: rtl/tmr_vote_pipe.sv
module tmr_vote_pipe
  import tmr_pkg::*;
#(
  parameter int unsigned N_STAGE = 7,
  parameter int unsigned STEP    = 32'h0013_579B
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [PAY_W-1:0]            data_i,
  input  logic [N_STAGE-1:0]          fault_en_i,
  input  logic [N_STAGE*LANE_W-1:0]   fault_lane_i,
  input  logic [N_STAGE*REC_W-1:0]    fault_val_i,
  output logic                        valid_o,
  output logic [PAY_W-1:0]            data_o,
  output logic [PAR_W-1:0]            parity_o,
  output logic [N_STAGE-1:0]          mismatch_o
);
  rec_t in_rec;
  rec_t lane_out [N_LANE][N_STAGE];
  rec_t voted    [N_STAGE];

  assign in_rec = '{vld: valid_i, par: calc_par(data_i), pay: data_i};

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    rec_t stage_in;
    rec_t f_val;
    if (s == 0) begin : g_first
      assign stage_in = in_rec;
    end else begin : g_next
      assign stage_in = voted[s-1];
    end
    assign f_val = rec_t'(fault_val_i[s*REC_W +: REC_W]);

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
      logic hit;
      assign hit = fault_en_i[s] && (fault_lane_i[s*LANE_W +: LANE_W] == LANE_W'(l));
      tmr_lane_stage #(.STEP(STEP), .STAGE_IDX(s)) u_ls (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_i        (stage_in),
        .fault_hit_i (hit),
        .fault_val_i (f_val),
        .out_o       (lane_out[l][s])
      );
    end

    tmr_voter u_vote (
      .a_i   (lane_out[0][s]),
      .b_i   (lane_out[1][s]),
      .c_i   (lane_out[2][s]),
      .maj_o (voted[s]),
      .mis_o (mismatch_o[s])
    );
  end

  assign valid_o  = voted[N_STAGE-1].vld;
  assign data_o   = voted[N_STAGE-1].pay;
  assign parity_o = voted[N_STAGE-1].par;
endmodule

// File: rtl/tmr_vote_pipe_chk.sv
module tmr_vote_pipe_chk
  import tmr_pkg::*;
#(
  parameter int unsigned N_STAGE = 7,
  parameter int unsigned STEP    = 32'h0013_579B
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [PAY_W-1:0]   data_i,
  input logic [N_STAGE-1:0] fault_en_i,
  input logic               valid_o,
  input logic [PAY_W-1:0]   data_o,
  input logic [PAR_W-1:0]   parity_o,
  input logic [N_STAGE-1:0] mismatch_o
);
  localparam logic [PAY_W-1:0] TOTAL =
    PAY_W'(N_STAGE * STEP + (N_STAGE * (N_STAGE - 1)) / 2);

  logic             h_v [N_STAGE];
  logic [PAY_W-1:0] h_d [N_STAGE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_STAGE; i++) begin
        h_v[i] <= 1'b0;
        h_d[i] <= '0;
      end
    end else begin
      h_v[0] <= valid_i;
      h_d[0] <= data_i;
      for (int i = 1; i < N_STAGE; i++) begin
        h_v[i] <= h_v[i-1];
        h_d[i] <= h_d[i-1];
      end
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == h_v[N_STAGE-1]);

  assert_payload_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o == h_d[N_STAGE-1] + TOTAL));

  assert_out_parity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_o == {^data_o[PAY_W-1:PAY_W/2], ^data_o[PAY_W/2-1:0]});

  assert_quiet_no_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_en_i == '0) |-> (mismatch_o == '0));

  assert_flag_needs_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_o & ~fault_en_i) == '0);
endmodule

bind tmr_vote_pipe tmr_vote_pipe_chk #(.N_STAGE(N_STAGE), .STEP(STEP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .data_i     (data_i),
  .fault_en_i (fault_en_i),
  .valid_o    (valid_o),
  .data_o     (data_o),
  .parity_o   (parity_o),
  .mismatch_o (mismatch_o)
);

// File: tb/tmr_vote_pipe_tb.sv
module tmr_vote_pipe_tb_top;
  localparam int unsigned NS    = 7;
  localparam int unsigned STEP  = 32'h0013_579B;
  localparam int unsigned PW    = 26;
  localparam int unsigned RW    = 29;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0;
  logic [PW-1:0]     data_i = '0;
  logic [NS-1:0]     fault_en_i = '0;
  logic [NS*2-1:0]   fault_lane_i = '0;
  logic [NS*RW-1:0]  fault_val_i = '0;
  logic              valid_o;
  logic [PW-1:0]     data_o;
  logic [1:0]        parity_o;
  logic [NS-1:0]     mismatch_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_vote_pipe #(.N_STAGE(NS), .STEP(STEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .fault_en_i(fault_en_i), .fault_lane_i(fault_lane_i), .fault_val_i(fault_val_i),
    .valid_o(valid_o), .data_o(data_o), .parity_o(parity_o), .mismatch_o(mismatch_o)
  );

  function automatic logic [1:0] bpar(input logic [PW-1:0] d);
    return {^d[25:13], ^d[12:0]};
  endfunction

  function automatic logic [PW-1:0] bstage(input int s, input logic [PW-1:0] d);
    return d + PW'(STEP + s);
  endfunction

  // bench model of the fault-free stage values
  logic          m_v [NS];
  logic [PW-1:0] m_d [NS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin m_v[i] <= 1'b0; m_d[i] <= '0; end
    end else begin
      m_v[0] <= valid_i;
      m_d[0] <= bstage(0, data_i);
      for (int i = 1; i < NS; i++) begin
        m_v[i] <= m_v[i-1];
        m_d[i] <= bstage(i, m_d[i-1]);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string dreq);
    logic [NS-1:0] exp_mis;
    logic [RW-1:0] truth;
    exp_mis = '0;
    for (int s = 0; s < NS; s++) begin
      truth = {m_v[s], bpar(m_d[s]), m_d[s]};
      if (fault_en_i[s] && fault_lane_i[2*s +: 2] != 2'd3 &&
          fault_val_i[s*RW +: RW] != truth)
        exp_mis[s] = 1'b1;
    end
    chk(valid_o == m_v[NS-1], "R2 R5", 32'(valid_o), 32'(m_v[NS-1]));
    if (m_v[NS-1]) chk(data_o == m_d[NS-1], dreq, 32'(data_o), 32'(m_d[NS-1]));
    chk(parity_o == bpar(data_o), "R4", 32'(parity_o), 32'(bpar(data_o)));
    chk(mismatch_o == exp_mis, "R7 R8", 32'(mismatch_o), 32'(exp_mis));
  endtask

  // mode 0: random faults, 1: every stage faulted, 2: none
  task automatic step(input int mode, input int cyc);
    @(negedge clk);
    valid_i = ($urandom_range(0, 3) != 0);
    data_i  = PW'($urandom());
    for (int s = 0; s < NS; s++) begin
      fault_val_i[s*RW +: RW] = RW'({$urandom(), $urandom()});
      if (mode == 1) begin
        fault_en_i[s] = 1'b1;
        fault_lane_i[2*s +: 2] = 2'((s + cyc) % 3);
      end else if (mode == 0) begin
        fault_en_i[s] = ($urandom_range(0, 2) == 0);
        fault_lane_i[2*s +: 2] = 2'($urandom_range(0, 3));
      end else begin
        fault_en_i[s] = 1'b0;
      end
    end
    #1;
    check_outputs(mode == 1 ? "R6" : "R3 R5");
  endtask

  initial begin
    #(2_000_000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #23;
    chk(valid_o == 1'b0 && data_o == '0 && parity_o == '0, "R1", {data_o, parity_o, valid_o}, 0);
    chk(mismatch_o == '0, "R1", 32'(mismatch_o), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(valid_o == 1'b0 && data_o == '0, "R1", 32'(data_o), 0);
    // directed: known value through a clean pipe (R3 boundary wrap)
    @(negedge clk);
    valid_i = 1'b1; data_i = '1;
    for (int i = 0; i < NS; i++) begin
      @(negedge clk); valid_i = 1'b0; #1;
      check_outputs("R3");
    end
    // directed: lane code 3 is ignored (R7)
    @(negedge clk);
    fault_en_i = '1; fault_lane_i = '1; fault_val_i = '1; #1;
    chk(mismatch_o == '0, "R7", 32'(mismatch_o), 0);
    check_outputs("R7");
    // directed: fault one stage, then clean cycle must be quiet (R8)
    step(2, 0);
    @(negedge clk);
    fault_en_i = 7'b0001000; fault_lane_i = '0; fault_val_i = '0;
    fault_val_i[3*RW +: RW] = ~{m_v[3], bpar(m_d[3]), m_d[3]}; #1;
    chk(mismatch_o == 7'b0001000, "R7", 32'(mismatch_o), 32'h8);
    step(2, 0);
    chk(mismatch_o == '0, "R8", 32'(mismatch_o), 0);
    for (int c = 0; c < 1500; c++) step(0, c);
    for (int c = 0; c < 300; c++)  step(1, c);
    for (int c = 0; c < 200; c++)  step(c % 2 == 0 ? 2 : 0, c);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule